// File: doc/BRIEF.md
# Video Memory Write Buffer Drainer

This block holds host data-port writes in a short queue and retires them into three video memories: a byte-wide main video memory, a 64-entry colour table and a 40-entry vertical-scroll table. The host offers 16-bit words over a valid/ready channel. Each word carries a timestamp in master clocks. A separate command decoder loads the running address, the access code and the auto-increment step.

The block keeps its own master-clock count and a line position that wraps every 3420 clocks. Each line is cut into access slots of 16 clocks (wide mode) or 20 clocks (narrow mode). The mode is taken at the start of each line. In the first clock of a slot, the block may retire at most one memory operation. It does so only when the slot is neither a fixed refresh slot nor marked busy by the display fetch logic, and only when the head word's timestamp has been reached. A main-memory word needs two slots, one for each byte. If a slot is open but has no eligible word, the block pulses an idle flag. Other logic can wait on that flag.

Back-pressure is simple. `push_ready` is high whenever the queue is not full. A word transfers in any clock in which both `push_valid` and `push_ready` are high. A host facing a full queue holds its word until a completed entry frees a place. A free place can only appear at an open slot.

Top module: `vmem_wbuf_drain`

## Requirements
- R1: The queue holds 4 words. `push_ready` is high exactly when it holds fewer than 4. `fifo_full` and `fifo_empty` report 4 and 0 entries. After reset the queue is empty, `cur_addr` is 0 and no strobe is active.
- R2: A push and a completed entry in the same clock leave the occupancy unchanged.
- R3: A word is not acted on before the clock whose master-clock count is at least its timestamp. A word still waiting for its timestamp blocks the words behind it.
- R4: A line is 3420 clocks long. Slot index and offset restart at line start, and slots are 16 clocks wide (`wide_mode`=1) or 20 clocks wide. A decision is made only in the first clock of a slot, and at most one operation is made per slot. A memory strobe appears in the clock after its decision.
- R5: Refresh slots are never used. In wide mode these are slot indices 73, 105, 137, 169 and 201. In narrow mode they are 66, 98, 130 and 162.
- R6: A slot whose first clock has `disp_busy` high is never used.
- R7: Code 1 (main memory). The first slot writes data[15:8] to `cur_addr` and keeps the word at the head. The second slot writes data[7:0] to `cur_addr` with bit 0 inverted and then removes the word.
- R8: Code 3 (colour table). One slot writes the whole word at `cur_addr[5:0]`.
- R9: Code 5 (vertical-scroll table). One slot writes the word at `cur_addr[5:0]`, but only when that index is below 40. Otherwise no strobe is issued, and the word is still removed and the address still advanced.
- R10: Any other code removes the word in one slot without a memory strobe.
- R11: Each completed word advances `cur_addr` by `autoinc`, modulo 2^16. `cmd_load` sets the address and the code. It takes priority over an advance in the same clock.
- R12: An open slot (not refresh, not busy) with no eligible word produces a one-clock `slot_idle` pulse in the following clock. Any other slot produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 1: 16-clock slots, 0: 20-clock slots; taken at line start |
| disp_busy | input | 1 | Current slot is taken by display fetch |
| push_valid | input | 1 | Host offers a word |
| push_ready | output | 1 | Queue can take a word |
| push_data | input | 16 | Word to store |
| push_stamp | input | 32 | Earliest master-clock count for retiring the word |
| cmd_load | input | 1 | Load address and code |
| cmd_addr | input | 16 | Address to load |
| cmd_code | input | 3 | Access code to load |
| autoinc | input | 8 | Address step per completed word |
| cur_addr | output | 16 | Running address |
| fifo_empty | output | 1 | Queue holds no word |
| fifo_full | output | 1 | Queue holds 4 words |
| slot_idle | output | 1 | Open slot found no eligible word |
| vram_we | output | 1 | Main memory byte write strobe |
| vram_addr | output | 16 | Main memory byte address |
| vram_wdata | output | 8 | Main memory byte |
| cram_we | output | 1 | Colour table write strobe |
| cram_addr | output | 6 | Colour table index |
| cram_wdata | output | 16 | Colour table word |
| vsram_we | output | 1 | Vertical-scroll table write strobe |
| vsram_addr | output | 6 | Vertical-scroll table index |
| vsram_wdata | output | 16 | Vertical-scroll table word |

## Verification
A host push and a queue removal can land on the same clock. That clock is the first clock of an open slot, when the host offers a word and the head word retires.

The bench provokes this case directly. It parks three colour words behind a busy signal. It then releases one slot and pushes in that exact clock. It expects the queue to be neither full nor empty afterwards, and to become full after one more push.

Random bursts with back-to-back pushes and random busy slots repeat the overlap many times. The complete ordered stream of memory writes is compared with the stream predicted from the pushed words, so a lost or duplicated entry is caught.

// File: rtl/vwd_pkg.sv
package vwd_pkg;

  localparam int STAMP_W = 32;
  localparam int WORD_W  = 16;

  localparam logic [2:0] CODE_VRAM  = 3'd1;
  localparam logic [2:0] CODE_CRAM  = 3'd3;
  localparam logic [2:0] CODE_VSRAM = 3'd5;

  typedef struct packed {
    logic [STAMP_W-1:0] stamp;
    logic [WORD_W-1:0]  data;
    logic               half;
  } wentry_t;

  function automatic logic slot_is_refresh(input logic wide, input int unsigned idx);
    if (wide)
      return (idx == 73) || (idx == 105) || (idx == 137) || (idx == 169) || (idx == 201);
    else
      return (idx == 66) || (idx == 98) || (idx == 130) || (idx == 162);
  endfunction

endpackage

// File: rtl/vwd_slot_timer.sv
module vwd_slot_timer
  import vwd_pkg::*;
#(
  parameter int LINE_CLKS   = 3420,
  parameter int NARROW_SLOT = 20,
  parameter int WIDE_SLOT   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wide_mode,
  input  logic               disp_busy,
  output logic [STAMP_W-1:0] cyc,
  output logic               slot_open
);
  localparam int MAX_SLOT = (NARROW_SLOT > WIDE_SLOT) ? NARROW_SLOT : WIDE_SLOT;
  localparam int MIN_SLOT = (NARROW_SLOT > WIDE_SLOT) ? WIDE_SLOT : NARROW_SLOT;
  localparam int LP_W     = $clog2(LINE_CLKS);
  localparam int SUB_W    = $clog2(MAX_SLOT);
  localparam int IDX_W    = $clog2(LINE_CLKS / MIN_SLOT + 1);

  logic [LP_W-1:0]  lpos;
  logic [SUB_W-1:0] sub;
  logic [IDX_W-1:0] sidx;
  logic             wide_q;
  logic             mode_eff, line_end, sub_end, on_refresh;

  assign mode_eff   = (lpos == '0) ? wide_mode : wide_q;
  assign line_end   = (lpos == LP_W'(LINE_CLKS - 1));
  assign sub_end    = (sub == (mode_eff ? SUB_W'(WIDE_SLOT - 1) : SUB_W'(NARROW_SLOT - 1)));
  assign on_refresh = slot_is_refresh(mode_eff, 32'(sidx));
  assign slot_open  = (sub == '0) && !on_refresh && !disp_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc    <= '0;
      lpos   <= '0;
      sub    <= '0;
      sidx   <= '0;
      wide_q <= 1'b0;
    end else begin
      cyc    <= cyc + 1'b1;
      wide_q <= mode_eff;
      if (line_end) begin
        lpos <= '0;
        sub  <= '0;
        sidx <= '0;
      end else begin
        lpos <= lpos + 1'b1;
        if (sub_end) begin
          sub  <= '0;
          sidx <= sidx + 1'b1;
        end else begin
          sub <= sub + 1'b1;
        end
      end
    end
  end

  // R4
  open_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_open |=> !slot_open);

endmodule

// File: rtl/vwd_fifo.sv
module vwd_fifo
  import vwd_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [WORD_W-1:0]  push_data,
  input  logic [STAMP_W-1:0] push_stamp,
  input  logic               pop,
  input  logic               mark_half,
  output wentry_t            head,
  output logic               empty,
  output logic               full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  wentry_t        store [DEPTH];
  logic [PW-1:0]  rd_ptr, wr_ptr;
  logic [CW-1:0]  count;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head  = store[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
    end else begin
      if (push) begin
        store[wr_ptr] <= '{stamp: push_stamp, data: push_data, half: 1'b0};
        wr_ptr <= bump(wr_ptr);
      end
      if (mark_half) store[rd_ptr].half <= 1'b1;
      if (pop) rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> (count == $past(count)));
  // R1
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/vwd_drain_ctrl.sv
module vwd_drain_ctrl
  import vwd_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int INC_W       = 8,
  parameter int CRAM_AW     = 6,
  parameter int VSRAM_AW    = 6,
  parameter int VSRAM_DEPTH = 40
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                slot_open,
  input  logic [STAMP_W-1:0]  cyc,
  input  wentry_t             head,
  input  logic                empty,
  input  logic                cmd_load,
  input  logic [ADDR_W-1:0]   cmd_addr,
  input  logic [2:0]          cmd_code,
  input  logic [INC_W-1:0]    autoinc,
  output logic                pop,
  output logic                mark_half,
  output logic [ADDR_W-1:0]   addr_q,
  output logic                slot_idle,
  output logic                vram_we,
  output logic [ADDR_W-1:0]   vram_addr,
  output logic [7:0]          vram_wdata,
  output logic                cram_we,
  output logic [CRAM_AW-1:0]  cram_addr,
  output logic [WORD_W-1:0]   cram_wdata,
  output logic                vsram_we,
  output logic [VSRAM_AW-1:0] vsram_addr,
  output logic [WORD_W-1:0]   vsram_wdata
);
  logic [2:0] code_q;
  logic       eligible, service, is_vram, vs_in_range;

  assign eligible    = !empty && (head.stamp <= cyc);
  assign service     = slot_open && eligible;
  assign is_vram     = (code_q == CODE_VRAM);
  assign mark_half   = service && is_vram && !head.half;
  assign pop         = service && !(is_vram && !head.half);
  assign vs_in_range = ({1'b0, addr_q[VSRAM_AW-1:0]} < (VSRAM_AW + 1)'(VSRAM_DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      code_q <= '0;
    end else if (cmd_load) begin
      addr_q <= cmd_addr;
      code_q <= cmd_code;
    end else if (pop) begin
      addr_q <= addr_q + ADDR_W'(autoinc);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vram_we     <= 1'b0;
      vram_addr   <= '0;
      vram_wdata  <= '0;
      cram_we     <= 1'b0;
      cram_addr   <= '0;
      cram_wdata  <= '0;
      vsram_we    <= 1'b0;
      vsram_addr  <= '0;
      vsram_wdata <= '0;
      slot_idle   <= 1'b0;
    end else begin
      vram_we     <= service && is_vram;
      vram_addr   <= {addr_q[ADDR_W-1:1], addr_q[0] ^ head.half};
      vram_wdata  <= head.half ? head.data[7:0] : head.data[15:8];
      cram_we     <= service && (code_q == CODE_CRAM);
      cram_addr   <= addr_q[CRAM_AW-1:0];
      cram_wdata  <= head.data;
      vsram_we    <= service && (code_q == CODE_VSRAM) && vs_in_range;
      vsram_addr  <= addr_q[VSRAM_AW-1:0];
      vsram_wdata <= head.data;
      slot_idle   <= slot_open && !eligible;
    end
  end

  // R4
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vram_we, cram_we, vsram_we, slot_idle}));
  // R9
  vsram_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vsram_we |-> ({1'b0, vsram_addr} < (VSRAM_AW + 1)'(VSRAM_DEPTH)));

endmodule

// File: rtl/vmem_wbuf_drain.sv
module vmem_wbuf_drain
  import vwd_pkg::*;
#(
  parameter int DEPTH       = 4,
  parameter int ADDR_W      = 16,
  parameter int INC_W       = 8,
  parameter int LINE_CLKS   = 3420,
  parameter int NARROW_SLOT = 20,
  parameter int WIDE_SLOT   = 16,
  parameter int CRAM_AW     = 6,
  parameter int VSRAM_AW    = 6,
  parameter int VSRAM_DEPTH = 40
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wide_mode,
  input  logic                disp_busy,
  input  logic                push_valid,
  output logic                push_ready,
  input  logic [15:0]         push_data,
  input  logic [31:0]         push_stamp,
  input  logic                cmd_load,
  input  logic [ADDR_W-1:0]   cmd_addr,
  input  logic [2:0]          cmd_code,
  input  logic [INC_W-1:0]    autoinc,
  output logic [ADDR_W-1:0]   cur_addr,
  output logic                fifo_empty,
  output logic                fifo_full,
  output logic                slot_idle,
  output logic                vram_we,
  output logic [ADDR_W-1:0]   vram_addr,
  output logic [7:0]          vram_wdata,
  output logic                cram_we,
  output logic [CRAM_AW-1:0]  cram_addr,
  output logic [15:0]         cram_wdata,
  output logic                vsram_we,
  output logic [VSRAM_AW-1:0] vsram_addr,
  output logic [15:0]         vsram_wdata
);
  logic [STAMP_W-1:0] cyc;
  logic               slot_open, push, pop, mark_half;
  wentry_t            head;

  assign push_ready = !fifo_full;
  assign push       = push_valid && push_ready;

  vwd_slot_timer #(
    .LINE_CLKS(LINE_CLKS), .NARROW_SLOT(NARROW_SLOT), .WIDE_SLOT(WIDE_SLOT)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .disp_busy(disp_busy),
    .cyc(cyc), .slot_open(slot_open)
  );

  vwd_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
    .push_stamp(push_stamp), .pop(pop), .mark_half(mark_half),
    .head(head), .empty(fifo_empty), .full(fifo_full)
  );

  vwd_drain_ctrl #(
    .ADDR_W(ADDR_W), .INC_W(INC_W), .CRAM_AW(CRAM_AW),
    .VSRAM_AW(VSRAM_AW), .VSRAM_DEPTH(VSRAM_DEPTH)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .slot_open(slot_open), .cyc(cyc), .head(head),
    .empty(fifo_empty), .cmd_load(cmd_load), .cmd_addr(cmd_addr),
    .cmd_code(cmd_code), .autoinc(autoinc), .pop(pop), .mark_half(mark_half),
    .addr_q(cur_addr), .slot_idle(slot_idle),
    .vram_we(vram_we), .vram_addr(vram_addr), .vram_wdata(vram_wdata),
    .cram_we(cram_we), .cram_addr(cram_addr), .cram_wdata(cram_wdata),
    .vsram_we(vsram_we), .vsram_addr(vsram_addr), .vsram_wdata(vsram_wdata)
  );

  // R6
  strobe_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vram_we || cram_we || vsram_we) |-> $past(slot_open));
  // R3
  stamp_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vram_we || cram_we || vsram_we) |-> ($past(head.stamp) <= $past(cyc)));
  // R7
  half_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mark_half |=> !fifo_empty);

endmodule

// File: tb/tb_vmem_wbuf_drain.sv
module tb_vmem_wbuf_drain;
  logic        clk = 1'b0, rst_n = 1'b0, wide_mode = 1'b0, disp_busy = 1'b0;
  logic        push_valid = 1'b0, cmd_load = 1'b0;
  logic [15:0] push_data = '0, cmd_addr = '0;
  logic [31:0] push_stamp = '0;
  logic [2:0]  cmd_code = '0;
  logic [7:0]  autoinc = '0;
  logic        push_ready, fifo_empty, fifo_full, slot_idle;
  logic [15:0] cur_addr, vram_addr, cram_wdata, vsram_wdata;
  logic [7:0]  vram_wdata;
  logic        vram_we, cram_we, vsram_we;
  logic [5:0]  cram_addr, vsram_addr;

  vmem_wbuf_drain dut (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .disp_busy(disp_busy),
    .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data),
    .push_stamp(push_stamp), .cmd_load(cmd_load), .cmd_addr(cmd_addr),
    .cmd_code(cmd_code), .autoinc(autoinc), .cur_addr(cur_addr),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .slot_idle(slot_idle),
    .vram_we(vram_we), .vram_addr(vram_addr), .vram_wdata(vram_wdata),
    .cram_we(cram_we), .cram_addr(cram_addr), .cram_wdata(cram_wdata),
    .vsram_we(vsram_we), .vsram_addr(vsram_addr), .vsram_wdata(vsram_wdata)
  );

  always #10 clk = ~clk;

  typedef struct {int kind; int addr; int data; int stamp;} ev_t;
  ev_t         expq[$];
  int          checks = 0, fails = 0, bcyc = 0, idle_cnt = 0;
  logic        busy_used = 1'b0;
  bit          busy_rand = 1'b0, cur_wide = 1'b0;
  logic [15:0] mdl_addr = '0;
  logic [7:0]  mdl_inc = '0;
  logic [2:0]  mdl_code = '0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (t=%0d)", tag, act, exp, bcyc);
    end
  endtask

  function automatic bit is_ref(input bit wide, input int idx);
    if (wide) return idx == 73 || idx == 105 || idx == 137 || idx == 169 || idx == 201;
    return idx == 66 || idx == 98 || idx == 130 || idx == 162;
  endfunction

  function automatic int slot_w();
    return cur_wide ? 16 : 20;
  endfunction

  always @(posedge clk) begin
    busy_used <= disp_busy;
    if (!rst_n) bcyc <= 0; else bcyc <= bcyc + 1;
  end

  // monitor: the decision cycle of a strobe seen now is bcyc-1
  always @(negedge clk) begin
    if (rst_n && bcyc > 0) begin
      int dc, lp, kind, a, d;
      dc = bcyc - 1;
      lp = dc % 3420;
      if (vram_we || cram_we || vsram_we || slot_idle) begin
        chk(lp % slot_w() == 0, "R4 slot offset", lp % slot_w(), 0);
        chk(!is_ref(cur_wide, lp / slot_w()), "R5 refresh slot used", lp / slot_w(), 0);
        chk(!busy_used, "R6 busy slot used", busy_used, 0);
      end
      if (slot_idle && dc < 3420) idle_cnt++;
      if (vram_we || cram_we || vsram_we) begin
        kind = vram_we ? 1 : (cram_we ? 2 : 3);
        a = vram_we ? int'(vram_addr) : (cram_we ? int'(cram_addr) : int'(vsram_addr));
        d = vram_we ? int'(vram_wdata) : (cram_we ? int'(cram_wdata) : int'(vsram_wdata));
        if (expq.size() == 0) begin
          chk(0, "R10 unexpected write", kind, 0);
        end else begin
          ev_t e;
          string tg;
          e = expq.pop_front();
          tg = (e.kind == 1) ? "R7" : ((e.kind == 2) ? "R8" : "R9");
          chk(kind == e.kind, {tg, " target"}, kind, e.kind);
          chk(a == e.addr, {tg, " address"}, a, e.addr);
          chk(d == e.data, {tg, " data"}, d, e.data);
          chk(dc >= e.stamp, "R3 early retire", dc, e.stamp);
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (busy_rand) disp_busy = ($urandom_range(0, 3) == 0);
    end
  end

  task automatic set_cmd(input logic [2:0] c, input logic [15:0] a, input logic [7:0] inc);
    @(negedge clk);
    cmd_load = 1'b1; cmd_code = c; cmd_addr = a; autoinc = inc;
    @(negedge clk);
    cmd_load = 1'b0;
    mdl_addr = a; mdl_code = c; mdl_inc = inc;
    chk(cur_addr == a, "R11 load", cur_addr, a);
  endtask

  // expected events from R7..R10, then address step from R11
  task automatic expect_word(input logic [15:0] d, input int st);
    case (mdl_code)
      3'd1: begin
        expq.push_back('{1, int'(mdl_addr), int'(d[15:8]), st});
        expq.push_back('{1, int'(mdl_addr ^ 16'h1), int'(d[7:0]), st});
      end
      3'd3: expq.push_back('{2, int'(mdl_addr[5:0]), int'(d), st});
      3'd5: if (mdl_addr[5:0] < 6'd40) expq.push_back('{3, int'(mdl_addr[5:0]), int'(d), st});
      default: ;
    endcase
    mdl_addr = mdl_addr + {8'h00, mdl_inc};
  endtask

  task automatic push_word(input logic [15:0] d, input int st);
    expect_word(d, st);
    @(negedge clk);
    push_valid = 1'b1; push_data = d; push_stamp = st;
    while (!push_ready) @(negedge clk);
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  task automatic wait_drain(input string tag);
    int n = 0;
    while (!fifo_empty && n < 20000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, {tag, " missing writes"}, expq.size(), 0);
    chk(cur_addr == mdl_addr, "R11 final address", cur_addr, mdl_addr);
    expq.delete();
  endtask

  task automatic run_mode(input bit wide);
    busy_rand = 1'b0; disp_busy = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    wide_mode = wide; cur_wide = wide; idle_cnt = 0; expq.delete();
    rst_n = 1'b1;
    chk(fifo_empty && !fifo_full && push_ready, "R1 reset flags", {fifo_empty, fifo_full, push_ready}, 3'b101);
    chk(cur_addr == 16'h0, "R1 reset address", cur_addr, 0);
    @(negedge clk);
    chk(!(vram_we || cram_we || vsram_we), "R1 reset strobes", {vram_we, cram_we, vsram_we}, 0);
    while (bcyc < 3422) @(negedge clk);
    chk(idle_cnt == (wide ? 209 : 167), "R12 idle pulses per line", idle_cnt, wide ? 209 : 167);

    set_cmd(3'd1, 16'h1234, 8'd2);
    push_word(16'hABCD, 0); push_word(16'h5678, 0);
    wait_drain("R7");
    set_cmd(3'd1, 16'h0101, 8'd1);
    push_word(16'h1357, 0);
    wait_drain("R7 odd");
    set_cmd(3'd3, 16'h0047, 8'd2);
    push_word(16'h0F0F, 0); push_word(16'h1E1E, 0);
    wait_drain("R8");
    set_cmd(3'd5, 16'h003E, 8'd2);
    push_word(16'h2222, 0); push_word(16'h3333, 0); push_word(16'h4444, 0);
    wait_drain("R9");
    set_cmd(3'd0, 16'h0010, 8'd4);
    push_word(16'h7777, 0); push_word(16'h8888, 0);
    wait_drain("R10");
    chk(cur_addr == 16'h0018, "R10 address advanced", cur_addr, 16'h0018);

    set_cmd(3'd3, 16'h0000, 8'd1);
    push_word(16'h0BAD, bcyc + 500);
    repeat (300) @(negedge clk);
    chk(!fifo_empty, "R3 held before stamp", fifo_empty, 0);
    wait_drain("R3");

    // same-clock push and removal
    disp_busy = 1'b1;
    set_cmd(3'd3, 16'h0010, 8'd1);
    push_word(16'h0001, 0); push_word(16'h0002, 0); push_word(16'h0003, 0);
    @(negedge clk);
    while (((bcyc % 3420) % slot_w()) != 0 || is_ref(wide, (bcyc % 3420) / slot_w())) @(negedge clk);
    expect_word(16'h0004, 0);
    disp_busy = 1'b0; push_valid = 1'b1; push_data = 16'h0004; push_stamp = 0;
    @(negedge clk);
    disp_busy = 1'b1; push_valid = 1'b0;
    chk(!fifo_full && !fifo_empty, "R2 count kept", {fifo_full, fifo_empty}, 0);
    push_word(16'h0005, 0);
    chk(fifo_full && !push_ready, "R1 full after fourth", {fifo_full, push_ready}, 2'b10);
    fork
      begin repeat (30) @(negedge clk); disp_busy = 1'b0; end
      push_word(16'h0006, 0);
    join
    wait_drain("R1 stall");

    busy_rand = 1'b1;
    for (int b = 0; b < 25; b++) begin
      int n;
      logic [2:0] codes [8] = '{3'd1, 3'd1, 3'd3, 3'd5, 3'd5, 3'd0, 3'd2, 3'd7};
      set_cmd(codes[$urandom_range(0, 7)], 16'($urandom), 8'($urandom_range(0, 4)));
      n = $urandom_range(1, 6);
      for (int k = 0; k < n; k++)
        push_word(16'($urandom), ($urandom_range(0, 3) == 0) ? bcyc + $urandom_range(0, 150) : 0);
      wait_drain("R4 random");
    end
    busy_rand = 1'b0; disp_busy = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5EED));
    run_mode(1'b0);
    run_mode(1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R4 watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule